// File: doc/BRIEF.md
# NAND Page ECC Error Corrector

This block decides what to do with a NAND page after readback. It takes two 32-bit ECC words: the one stored with the page and the one computed again from the data that was read. It XORs them into a syndrome and reports one of four outcomes. The page may be clean. It may hold one flipped data bit, which the block locates by byte address and bit index. The stored ECC word itself may hold one flipped bit, in which case the data is good. Finally, the damage may be too large to correct. A controller pulses `start` with both words and the page size, and reads the verdict one clock later. Flipping the bit in page memory is the caller's job.

Each 32-bit ECC word holds complementary parity pairs. Bits 1:0 hold column pair 1 (bit 0 is the true member, bit 1 the complement). Bits 3:2 hold column pair 2 and bits 5:4 hold column pair 4, in the same order. Line pair k (k = 0..11) sits at bits 6+2k (true) and 7+2k (complement). Bits 31:30 are never used. The page size selects how many line pairs take part: 9, 10, 11 or 12 of them. The syndrome keeps only the bits that take part. For a single data-bit error, each active pair has exactly one member set. The true member of each pair then gives one bit of the error location.

Top module: `nand_ecc_corrector`

## Requirements
- R1: During and after synchronous reset, with no start, `res_valid` is 0, `res_status` is 0, and `err_byte` and `err_bit` are 0.
- R2: `res_valid` is 1 in the cycle after a cycle with `start` = 1, and only then. Back-to-back starts give back-to-back results.
- R3: `page_sel` encodes the page size: 0 = 512 bytes (line pairs 0..8 active), 1 = 1024 (0..9), 2 = 2048 (0..10), 3 = 4096 (0..11). Syndrome bits of inactive line pairs and bits 31:30 have no effect on any output.
- R4: A masked syndrome of all zeros gives status 0 (clean).
- R5: If every active pair (the three column pairs plus the active line pairs) has exactly one member set, the status is 1 (data error).
- R6: With status 1, `err_bit` = {syndrome bit 4, bit 2, bit 0}, and `err_byte` bit k = syndrome bit 6+2k for each active line pair k. The upper `err_byte` bits are 0, so `err_byte` is below the page size.
- R7: A masked syndrome with exactly one bit set gives status 2 (error in the ECC word), and the data needs no change.
- R8: Any other masked syndrome gives status 3 (uncorrectable). This covers every two-bit error and every larger pattern that does not meet R5.
- R9: When the status is not 1, `err_byte` and `err_bit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Evaluate the words presented this cycle |
| page_sel | input | 2 | Page size code (R3) |
| ecc_stored | input | 32 | ECC word read back from the spare area |
| ecc_calc | input | 32 | ECC word recomputed from the read data |
| res_valid | output | 1 | Result valid pulse |
| res_status | output | 2 | 0 clean, 1 data error, 2 ECC-word error, 3 uncorrectable |
| err_byte | output | 12 | Byte address of the bad bit |
| err_bit | output | 3 | Bit index inside that byte |

## Verification
The bench builds the block with its default parameters: three column pairs, 9 to 12 line pairs and a 32-bit word. With these values every one of the four page sizes can be tested. The tests cover data-error locations at address 0, at the top address of each page size, and at bit positions 0 and 7. Single flips go into the column bits and into the highest active line bit. Flips go into the first inactive pair and into the spare bits 31:30. Two-bit and three-bit damage, and a run of random syndromes, are also tested. A behavioural reference model is compared against the outputs on every clock.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  typedef enum logic [1:0] {
    ST_CLEAN   = 2'd0,
    ST_DATA    = 2'd1,
    ST_ECCWORD = 2'd2,
    ST_UNCORR  = 2'd3
  } ecc_status_t;
endpackage

// File: rtl/ecc_active_mask.sv
module ecc_active_mask #(
  parameter int ECC_W      = 32,
  parameter int COL_PAIRS  = 3,
  parameter int LINE_MIN   = 9,
  parameter int LINE_MAX   = 12,
  parameter int SEL_W      = 2
) (
  input  logic [SEL_W-1:0] page_sel,
  output logic [ECC_W-1:0] mask
);
  localparam int COL_BITS  = 2 * COL_PAIRS;
  localparam int USED_BITS = COL_BITS + 2 * LINE_MAX;

  // Column pairs are always active.
  for (genvar c = 0; c < COL_BITS; c++) begin : g_col
    assign mask[c] = 1'b1;
  end

  // Line pair k is active when k is below the count for this page size.
  for (genvar k = 0; k < LINE_MAX; k++) begin : g_line
    logic act;
    assign act = (k < (LINE_MIN + int'(page_sel)));
    assign mask[COL_BITS + 2*k]     = act;
    assign mask[COL_BITS + 2*k + 1] = act;
  end

  // Bits above the highest line pair are spare.
  if (USED_BITS < ECC_W) begin : g_spare
    assign mask[ECC_W-1:USED_BITS] = '0;
  end
endmodule

// File: rtl/ecc_syndrome_classify.sv
module ecc_syndrome_classify #(
  parameter int ECC_W     = 32,
  parameter int COL_PAIRS = 3,
  parameter int LINE_MAX  = 12
) (
  input  logic [ECC_W-1:0] ecc_stored,
  input  logic [ECC_W-1:0] ecc_calc,
  input  logic [ECC_W-1:0] mask,
  output logic [ECC_W-1:0] syn,
  output logic             syn_zero,
  output logic             pairs_split,
  output logic             one_hot
);
  localparam int NPAIRS = COL_PAIRS + LINE_MAX;
  localparam int CNT_W  = $clog2(ECC_W + 1);

  logic [NPAIRS-1:0] pair_ok;
  logic [CNT_W-1:0]  ones;

  assign syn = (ecc_stored ^ ecc_calc) & mask;

  // An inactive pair places no constraint. An active pair must have
  // exactly one member set.
  for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
    assign pair_ok[p] = ~mask[2*p] | (syn[2*p] ^ syn[2*p+1]);
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < ECC_W; i++) begin
      ones = ones + CNT_W'(syn[i]);
    end
  end

  assign syn_zero    = (syn == '0);
  assign pairs_split = &pair_ok;
  assign one_hot     = (ones == CNT_W'(1));
endmodule

// File: rtl/ecc_locate.sv
module ecc_locate #(
  parameter int ECC_W     = 32,
  parameter int COL_PAIRS = 3,
  parameter int LINE_MAX  = 12
) (
  input  logic [ECC_W-1:0]     syn,
  output logic [LINE_MAX-1:0]  byte_addr,
  output logic [COL_PAIRS-1:0] bit_idx
);
  localparam int COL_BITS = 2 * COL_PAIRS;

  // The true member of each pair supplies one location bit. Inactive
  // pairs are already masked to zero.
  for (genvar c = 0; c < COL_PAIRS; c++) begin : g_bit
    assign bit_idx[c] = syn[2*c];
  end
  for (genvar k = 0; k < LINE_MAX; k++) begin : g_addr
    assign byte_addr[k] = syn[COL_BITS + 2*k];
  end
endmodule

// File: rtl/nand_ecc_corrector.sv
module nand_ecc_corrector
  import nand_ecc_pkg::*;
#(
  parameter int ECC_W     = 32,
  parameter int COL_PAIRS = 3,
  parameter int LINE_MIN  = 9,
  parameter int LINE_MAX  = 12,
  parameter int SEL_W     = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [SEL_W-1:0]     page_sel,
  input  logic [ECC_W-1:0]     ecc_stored,
  input  logic [ECC_W-1:0]     ecc_calc,
  output logic                 res_valid,
  output logic [1:0]           res_status,
  output logic [LINE_MAX-1:0]  err_byte,
  output logic [COL_PAIRS-1:0] err_bit
);
  logic [ECC_W-1:0]     mask;
  logic [ECC_W-1:0]     syn;
  logic                 syn_zero, pairs_split, one_hot;
  logic [LINE_MAX-1:0]  loc_byte;
  logic [COL_PAIRS-1:0] loc_bit;
  ecc_status_t          st_next;

  ecc_active_mask #(
    .ECC_W(ECC_W), .COL_PAIRS(COL_PAIRS), .LINE_MIN(LINE_MIN),
    .LINE_MAX(LINE_MAX), .SEL_W(SEL_W)
  ) u_mask (
    .page_sel (page_sel),
    .mask     (mask)
  );

  ecc_syndrome_classify #(
    .ECC_W(ECC_W), .COL_PAIRS(COL_PAIRS), .LINE_MAX(LINE_MAX)
  ) u_class (
    .ecc_stored  (ecc_stored),
    .ecc_calc    (ecc_calc),
    .mask        (mask),
    .syn         (syn),
    .syn_zero    (syn_zero),
    .pairs_split (pairs_split),
    .one_hot     (one_hot)
  );

  ecc_locate #(
    .ECC_W(ECC_W), .COL_PAIRS(COL_PAIRS), .LINE_MAX(LINE_MAX)
  ) u_loc (
    .syn       (syn),
    .byte_addr (loc_byte),
    .bit_idx   (loc_bit)
  );

  always_comb begin
    if (syn_zero)         st_next = ST_CLEAN;
    else if (pairs_split) st_next = ST_DATA;
    else if (one_hot)     st_next = ST_ECCWORD;
    else                  st_next = ST_UNCORR;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_status <= ST_CLEAN;
      err_byte   <= '0;
      err_bit    <= '0;
    end else begin
      res_valid <= start;
      if (start) begin
        res_status <= st_next;
        if (st_next == ST_DATA) begin
          err_byte <= loc_byte;
          err_bit  <= loc_bit;
        end else begin
          err_byte <= '0;
          err_bit  <= '0;
        end
      end
    end
  end

  AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    start |=> res_valid); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !start |=> !res_valid); // R2
  AST_CLEAN_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
    (start && ((ecc_stored ^ ecc_calc) & mask) == '0) |=> res_status == ST_CLEAN); // R4
  AST_LOC_ZERO_IF_NOT_DATA: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_status != ST_DATA) |-> (err_byte == '0 && err_bit == '0)); // R9
  AST_ADDR_IN_PAGE: assert property (@(posedge clk) disable iff (rst)
    start |=> ((err_byte >> (LINE_MIN + int'($past(page_sel)))) == '0)); // R6
  AST_SINGLE_FLIP_ECCWORD: assert property (@(posedge clk) disable iff (rst)
    (start && $countones((ecc_stored ^ ecc_calc) & mask) == 1) |=> res_status == ST_ECCWORD); // R7
endmodule

// File: tb/nand_ecc_corrector_tb.sv
module nand_ecc_corrector_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [1:0]  page_sel;
  logic [31:0] ecc_stored, ecc_calc;
  logic        res_valid;
  logic [1:0]  res_status;
  logic [11:0] err_byte;
  logic [2:0]  err_bit;

  int n_cmp = 0;
  int n_bad = 0;

  // expectation for the outputs after the next rising edge
  logic        e_valid;
  logic [1:0]  e_status;
  logic [11:0] e_byte;
  logic [2:0]  e_bit;
  string       e_req;

  always #4 clk = ~clk;

  nand_ecc_corrector u_dut (
    .clk(clk), .rst(rst), .start(start), .page_sel(page_sel),
    .ecc_stored(ecc_stored), .ecc_calc(ecc_calc),
    .res_valid(res_valid), .res_status(res_status),
    .err_byte(err_byte), .err_bit(err_bit)
  );

  // Behavioural model of the requirements.
  task automatic model(input logic [31:0] s, input logic [31:0] c, input int sel,
                       output logic [1:0] st, output logic [11:0] ab, output logic [2:0] bi);
    int npairs;
    int ones;
    bit split;
    logic [31:0] d;
    npairs = 9 + sel;
    d = s ^ c;
    for (int i = 0; i < 32; i++) begin
      if (i >= 6 + 2*npairs) d[i] = 1'b0;
    end
    ones = 0;
    for (int i = 0; i < 32; i++) ones += d[i];
    split = 1;
    for (int p = 0; p < 3 + npairs; p++) begin
      if (d[2*p] == d[2*p+1]) split = 0;
    end
    ab = '0; bi = '0;
    if (ones == 0) st = 2'd0;
    else if (split) begin
      st = 2'd1;
      bi = {d[4], d[2], d[0]};
      for (int k = 0; k < npairs; k++) ab[k] = d[6+2*k];
    end
    else if (ones == 1) st = 2'd2;
    else st = 2'd3;
  endtask

  // syndrome of a single data-bit error at (addr, bitpos)
  function automatic logic [31:0] data_err(int addr, int bitpos, int sel);
    logic [31:0] v;
    v = '0;
    for (int c = 0; c < 3; c++) v[2*c + ((bitpos >> c) & 1 ? 0 : 1)] = 1'b1;
    for (int k = 0; k < 9 + sel; k++) v[6 + 2*k + ((addr >> k) & 1 ? 0 : 1)] = 1'b1;
    return v;
  endfunction

  task automatic compare();
    n_cmp++;
    if (res_valid !== e_valid || (e_valid &&
        (res_status !== e_status || err_byte !== e_byte || err_bit !== e_bit))) begin
      n_bad++;
      $display("FAIL %s: got v=%0b st=%0d byte=%0d bit=%0d exp v=%0b st=%0d byte=%0d bit=%0d",
               e_req, res_valid, res_status, err_byte, err_bit,
               e_valid, e_status, e_byte, e_bit);
    end
  endtask

  // One clock: check the last expectation, then drive and predict the next.
  task automatic step(input bit go, input int sel, input logic [31:0] s,
                      input logic [31:0] c, input string req);
    logic [1:0] st; logic [11:0] ab; logic [2:0] bi;
    @(negedge clk);
    compare();
    start = go; page_sel = sel[1:0]; ecc_stored = s; ecc_calc = c;
    e_valid = go; e_req = req;
    if (go) begin
      model(s, c, sel, st, ab, bi);
      e_status = st; e_byte = ab; e_bit = bi;
    end
  endtask

  task automatic run(input int sel, input logic [31:0] s, input logic [31:0] c, input string req);
    step(1, sel, s, c, req);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] base;
    rst = 1'b1; start = 0; page_sel = 0; ecc_stored = 0; ecc_calc = 0;
    e_valid = 0; e_status = 0; e_byte = 0; e_bit = 0; e_req = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    n_cmp++;
    if (res_valid !== 1'b0 || res_status !== 2'd0 || err_byte !== 0 || err_bit !== 0) begin
      n_bad++;
      $display("FAIL R1: got v=%0b st=%0d byte=%0d bit=%0d exp all zero",
               res_valid, res_status, err_byte, err_bit);
    end
    rst = 1'b0;
    step(0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, "R2");
    base = 32'hA5C3_1E6B;
    for (int sel = 0; sel < 4; sel++) begin
      int top;
      top = (512 << sel) - 1;
      run(sel, base, base, "R4");
      run(sel, base, base ^ data_err(0, 0, sel), "R5 R6");
      run(sel, base, base ^ data_err(top, 7, sel), "R5 R6");
      run(sel, base, base ^ data_err(top >> 1, 3, sel), "R6");
      run(sel, base, base ^ 32'h1, "R7");
      run(sel, base, base ^ (32'h1 << (7 + 2*(8+sel))), "R7");
      step(0, sel, 0, 0, "R2");
      run(sel, base, base ^ 32'h3, "R8");
      run(sel, base, base ^ 32'h0000_0041, "R8 R9");
      run(sel, base, base ^ 32'h0000_0015, "R8");
      run(sel, base, base ^ 32'hC000_0000, "R3");
      if (sel < 3) begin
        run(sel, base, base ^ (32'h3 << (6 + 2*(9+sel))), "R3");
        run(sel, base, base ^ data_err(5, 2, sel) ^ (32'h1 << (6 + 2*(9+sel))), "R3 R6");
      end
      base = {base[30:0], base[31] ^ base[21]};
    end
    // data-error pattern for 4096 seen by 512: upper pairs masked, still data
    run(0, 0, data_err(4095, 5, 3), "R3 R5");
    for (int i = 0; i < 300; i++) begin
      int sel;
      logic [31:0] s, c;
      sel = $urandom_range(0, 3);
      s = $urandom;
      case (i % 4)
        0: c = s ^ data_err($urandom_range(0, (512 << sel) - 1), $urandom_range(0, 7), sel);
        1: c = s ^ (32'h1 << $urandom_range(0, 31));
        2: c = s ^ (32'h1 << $urandom_range(0, 15)) ^ (32'h1 << $urandom_range(16, 31));
        default: c = $urandom;
      endcase
      step((i % 7) != 3, sel, s, c, "R2 R5 R7 R8");
    end
    step(0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, "R2");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule